// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block decides, sample by sample, whether a digitizer's converted samples go into the acquisition stream. Software sets up a source, an edge direction, one of four modes and a few counts, then pulses an arm input. The block then waits for a trigger and raises a write enable on the sample-valid cycles that belong to the capture. Memory, DMA and host transfer sit outside the block.

The four modes are:
- **Post:** capture a fixed number of samples after the trigger.
- **Delayed:** skip a number of samples, then capture a fixed number.
- **Pre:** write into a circular window until the trigger. Triggers are refused until the window holds the required number of samples.
- **Middle:** the pre window, followed by a fixed number of samples after the trigger.

Post and delayed captures can be repeated on further triggers. In every mode the block reports the write address current when the trigger was taken, so the caller can locate the window in the circular store.

Top module: `acq_trig_ctrl`

## Requirements
- R1: While reset is held: busy, done, write enable, trigger-accepted, position-valid and the write address are all 0.
- R2: Arm while idle does the following, and arm while busy has no effect:
  - latches source, edge, mode and counts;
  - clears done, position-valid and the write address;
  - sets busy from the next cycle.
- R3: Source code 0 selects the software strobe, accepted in the cycle it is high. Code 1 selects the external line and code 2 the system-sync line, which is rising-edge only. Code 3 selects no source. Triggers from unselected sources are ignored.
- R4: The external line passes two synchroniser flops. A rising edge (edge bit 0) or falling edge (edge bit 1) of the line makes the trigger-accepted output visible in the second cycle after the cycle in which the line changed.
- R5: Post mode (code 0): after a trigger accepted in cycle t, the next post-count valid samples are written, from t+1 onward. The trigger-cycle sample is not written.
- R6: Delayed mode (code 1): after the trigger, delay-count valid samples are skipped without writing, then post-count samples are written.
- R7: Pre mode (code 2): writing starts the cycle after arm. A trigger is ignored until pre-count samples have been written. The sample coincident with the accepted trigger is written, and acquisition then ends.
- R8: Middle mode (code 3): behaves as pre mode up to and including the trigger sample, then writes post-count further samples.
- R9: In post and delayed modes, retrigger-count further triggers are each accepted and each start a new segment. A trigger during a segment is ignored, so in post mode triggers closer than post-count+1 cycles are dropped. Pre and middle modes accept exactly one trigger.
- R10: On each accepted trigger, the trigger position takes the write address of that cycle, and position-valid rises in the next cycle.
- R11: The write address steps by one per written sample and wraps modulo 2^AW.
- R12: Done rises the cycle after the final segment ends, together with busy falling, and holds until the next arm. Triggers arriving while idle are ignored.
- R13: Only cycles with sample-valid high are written or counted toward pre, delay and post counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Start pulse, accepted only while idle |
| sample_vld_i | input | 1 | A converted sample is present this cycle |
| sw_trig_i | input | 1 | Software trigger strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| sync_trig_i | input | 1 | System-sync trigger line |
| src_sel_i | input | 2 | Trigger source select |
| ext_fall_i | input | 1 | External edge: 0 rising, 1 falling |
| mode_i | input | 2 | 0 post, 1 delayed, 2 pre, 3 middle |
| pre_cnt_i | input | CW | Pre-trigger sample quota |
| post_cnt_i | input | CW | Post-trigger samples per segment (min 1) |
| delay_cnt_i | input | CW | Samples skipped after trigger in delayed mode |
| retrig_cnt_i | input | RW | Extra triggers accepted in post/delayed mode |
| wr_en_o | output | 1 | Write this cycle's sample |
| wr_addr_o | output | AW | Circular write address |
| trig_pos_o | output | AW | Write address at the last accepted trigger |
| trig_pos_vld_o | output | 1 | Trigger position captured since arm |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | Acquisition finished |
| trig_acc_o | output | 1 | A trigger is accepted this cycle |

## Verification
A table walks each mode with single and repeated software triggers. The write counts, done cycles and trigger positions it expects separate the modes:
- post from delayed, by the cycles skipped;
- pre from middle, by the tail written after the trigger;
- repeated from single capture, by the number of accepted triggers.

Directed patterns then probe the edges of the function:
- triggers in the last fill cycle and the last post cycle, against one cycle later;
- each edge direction of the external line, and the sync line under the falling setting;
- strobes on unselected or disabled sources;
- arm during a capture;
- sample-valid held low on alternate cycles;
- a pre window long enough to wrap the address.

// File: rtl/acq_trig_pkg.sv
// Shared encodings for the acquisition trigger controller.
package acq_trig_pkg;
    // Acquisition mode codes as seen on mode_i.
    typedef enum logic [1:0] {
        MODE_POST  = 2'd0,
        MODE_DELAY = 2'd1,
        MODE_PRE   = 2'd2,
        MODE_MID   = 2'd3
    } acq_mode_e;

    // Trigger source codes as seen on src_sel_i.
    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_SYNC = 2'd2,
        SRC_OFF  = 2'd3
    } trig_src_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DELAY = 3'd3,
        ST_POST  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/trig_edge_det.sv
// Synchronises an asynchronous line through SYNC_STAGES flops and flags one
// edge per transition. fall_i picks the falling edge instead of the rising one.
// Assumes line_i is held for at least two clock periods.
module trig_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic fall_i,
    output logic evt_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], line_i};
    end

    // Compare the synchronised level with its previous value.
    always_comb begin
        if (fall_i) evt_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
        else        evt_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    end
endmodule

// File: rtl/trig_src_mux.sv
// Latches source select and external edge direction at arm, detects edges on
// the external and sync lines, and forwards the selected trigger event.
// Assumes the software strobe is already synchronous to clk.
module trig_src_mux
    import acq_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] src_i,
    input  logic       fall_i,
    input  logic       sw_i,
    input  logic       ext_i,
    input  logic       sync_i,
    output logic       evt_o
);
    trig_src_e src_q;
    logic      fall_q;
    logic      ext_evt;
    logic      sync_evt;

    // Hold the source configuration for the whole acquisition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_OFF;
            fall_q <= 1'b0;
        end else if (load_i) begin
            src_q  <= trig_src_e'(src_i);
            fall_q <= fall_i;
        end
    end

    trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ext_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (ext_i),
        .fall_i (fall_q),
        .evt_o  (ext_evt)
    );

    trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_sync_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sync_i),
        .fall_i (1'b0),
        .evt_o  (sync_evt)
    );

    // Pick the event of the latched source.
    always_comb begin
        unique case (src_q)
            SRC_SW:   evt_o = sw_i;
            SRC_EXT:  evt_o = ext_evt;
            SRC_SYNC: evt_o = sync_evt;
            default:  evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/acq_seq.sv
// Acquisition sequencer: fills the pre window, waits for a trigger, skips the
// delay, writes post segments and handles retriggers. Counts only valid
// samples. Assumes post_i >= 1; a zero post count yields a single sample.
module acq_seq
    import acq_trig_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          evt_i,
    input  logic          vld_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] pre_i,
    input  logic [CW-1:0] post_i,
    input  logic [CW-1:0] dly_i,
    input  logic [RW-1:0] retrig_i,
    output logic          wr_en_o,
    output logic          acc_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          start_o
);
    localparam int XW = CW + 1;

    seq_state_e    st_q;
    acq_mode_e     mode_q;
    acq_mode_e     mode_in;
    logic [CW-1:0] pre_q, post_q, dly_q, cnt_q;
    logic [RW-1:0] rt_q;
    logic          done_q;
    logic          pre_side, pre_side_in;
    logic          fill_last, dly_last, post_last;
    logic [XW-1:0] cnt_nx;

    // Decode mode families and last-sample conditions.
    always_comb begin
        mode_in     = acq_mode_e'(mode_i);
        pre_side    = (mode_q == MODE_PRE) || (mode_q == MODE_MID);
        pre_side_in = (mode_in == MODE_PRE) || (mode_in == MODE_MID);
        cnt_nx      = {1'b0, cnt_q} + XW'(1);
        fill_last   = cnt_nx >= {1'b0, pre_q};
        dly_last    = cnt_nx >= {1'b0, dly_q};
        post_last   = cnt_nx >= {1'b0, post_q};
    end

    // Outputs derived from state and the current cycle's inputs.
    always_comb begin
        start_o = arm_i && (st_q == ST_IDLE);
        acc_o   = (st_q == ST_WAIT) && evt_i;
        wr_en_o = vld_i && ((st_q == ST_FILL) || (st_q == ST_POST) ||
                            ((st_q == ST_WAIT) && pre_side));
        busy_o  = (st_q != ST_IDLE);
        done_o  = done_q;
    end

    // State machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_POST;
            pre_q  <= '0;
            post_q <= '0;
            dly_q  <= '0;
            cnt_q  <= '0;
            rt_q   <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (arm_i) begin
                        mode_q <= mode_in;
                        pre_q  <= pre_i;
                        post_q <= post_i;
                        dly_q  <= dly_i;
                        cnt_q  <= '0;
                        done_q <= 1'b0;
                        rt_q   <= pre_side_in ? '0 : retrig_i;
                        st_q   <= (pre_side_in && (pre_i != '0)) ? ST_FILL : ST_WAIT;
                    end
                end
                ST_FILL: begin
                    if (vld_i) begin
                        if (fill_last) begin
                            st_q  <= ST_WAIT;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (evt_i) begin
                        cnt_q <= '0;
                        unique case (mode_q)
                            MODE_PRE: begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                            MODE_DELAY: st_q <= (dly_q == '0) ? ST_POST : ST_DELAY;
                            default:    st_q <= ST_POST;
                        endcase
                    end
                end
                ST_DELAY: begin
                    if (vld_i) begin
                        if (dly_last) begin
                            st_q  <= ST_POST;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_POST: begin
                    if (vld_i) begin
                        if (post_last) begin
                            cnt_q <= '0;
                            if (rt_q != '0) begin
                                rt_q <= rt_q - 1'b1;
                                st_q <= ST_WAIT;
                            end else begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/acq_addr_ctr.sv
// Circular write-address counter with trigger position capture.
// Assumes start_i and wr_en_i never coincide (writes only happen while busy).
module acq_addr_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          wr_en_i,
    input  logic          acc_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] pos_o,
    output logic          pos_vld_o
);
    logic [AW-1:0] addr_q, pos_q;
    logic          pos_vld_q;

    // Advance the address per write; clear it at arm.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (start_i) addr_q <= '0;
        else if (wr_en_i) addr_q <= addr_q + 1'b1;
    end

    // Record the address of the accepted trigger cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= '0;
            pos_vld_q <= 1'b0;
        end else if (start_i) begin
            pos_vld_q <= 1'b0;
        end else if (acc_i) begin
            pos_q     <= addr_q;
            pos_vld_q <= 1'b1;
        end
    end

    assign addr_o    = addr_q;
    assign pos_o     = pos_q;
    assign pos_vld_o = pos_vld_q;
endmodule

// File: rtl/acq_trig_ctrl.sv
// Top of the acquisition trigger controller: source selection, sequencer and
// write-address tracking. Assumes configuration inputs are stable at arm.
module acq_trig_ctrl #(
    parameter int CW          = 16,
    parameter int AW          = 8,
    parameter int RW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          sample_vld_i,
    input  logic          sw_trig_i,
    input  logic          ext_trig_i,
    input  logic          sync_trig_i,
    input  logic [1:0]    src_sel_i,
    input  logic          ext_fall_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] pre_cnt_i,
    input  logic [CW-1:0] post_cnt_i,
    input  logic [CW-1:0] delay_cnt_i,
    input  logic [RW-1:0] retrig_cnt_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] trig_pos_o,
    output logic          trig_pos_vld_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          trig_acc_o
);
    logic start;
    logic evt;

    trig_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start),
        .src_i  (src_sel_i),
        .fall_i (ext_fall_i),
        .sw_i   (sw_trig_i),
        .ext_i  (ext_trig_i),
        .sync_i (sync_trig_i),
        .evt_o  (evt)
    );

    acq_seq #(.CW(CW), .RW(RW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .evt_i    (evt),
        .vld_i    (sample_vld_i),
        .mode_i   (mode_i),
        .pre_i    (pre_cnt_i),
        .post_i   (post_cnt_i),
        .dly_i    (delay_cnt_i),
        .retrig_i (retrig_cnt_i),
        .wr_en_o  (wr_en_o),
        .acc_o    (trig_acc_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .start_o  (start)
    );

    acq_addr_ctr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .wr_en_i   (wr_en_o),
        .acc_i     (trig_acc_o),
        .addr_o    (wr_addr_o),
        .pos_o     (trig_pos_o),
        .pos_vld_o (trig_pos_vld_o)
    );
endmodule

// File: rtl/acq_trig_ctrl_chk.sv
// Port-level protocol checks for acq_trig_ctrl, attached by bind.
module acq_trig_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm_i,
    input logic          sample_vld_i,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [AW-1:0] trig_pos_o,
    input logic          trig_pos_vld_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          trig_acc_o
);
    // R12
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R12
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o);

    // R12
    accept_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc_o |-> busy_o);

    // R13
    write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sample_vld_i);

    // R2
    arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !busy_o) |=> (busy_o && !done_o && !trig_pos_vld_o && wr_addr_o == '0));

    // R10
    pos_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc_o |=> (trig_pos_vld_o && trig_pos_o == $past(wr_addr_o)));

    // R11
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (wr_addr_o == AW'($past(wr_addr_o) + 1'b1)));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !arm_i) |=> $stable(wr_addr_o));
endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm_i          (arm_i),
    .sample_vld_i   (sample_vld_i),
    .wr_en_o        (wr_en_o),
    .wr_addr_o      (wr_addr_o),
    .trig_pos_o     (trig_pos_o),
    .trig_pos_vld_o (trig_pos_vld_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .trig_acc_o     (trig_acc_o)
);

// File: tb/acq_trig_ctrl_tb.sv
module acq_trig_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] pre;
        logic [7:0] post;
        logic [7:0] dly;
        logic [3:0] rt;
        logic [7:0] ewr;
        logic [3:0] eacc;
        logic [7:0] edone;
        logic [7:0] epos;
    } vec_t;

    // mode pre post dly rt | writes accepts done-cycle position
    localparam vec_t TBL [0:6] = '{
        '{2'd0, 8'd0, 8'd5, 8'd0, 4'd0, 8'd5,  4'd1, 8'd9,  8'd0},
        '{2'd0, 8'd0, 8'd4, 8'd0, 4'd2, 8'd12, 4'd3, 8'd22, 8'd8},
        '{2'd1, 8'd0, 8'd4, 8'd3, 4'd1, 8'd8,  4'd2, 8'd21, 8'd4},
        '{2'd2, 8'd6, 8'd1, 8'd0, 4'd0, 8'd9,  4'd1, 8'd10, 8'd8},
        '{2'd3, 8'd4, 8'd5, 8'd0, 4'd0, 8'd12, 4'd1, 8'd13, 8'd6},
        '{2'd2, 8'd0, 8'd1, 8'd0, 4'd0, 8'd3,  4'd1, 8'd4,  8'd2},
        '{2'd3, 8'd2, 8'd3, 8'd0, 4'd2, 8'd8,  4'd1, 8'd9,  8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, vld = 1'b1, sw = 1'b0, ext = 1'b0, sy = 1'b0;
    logic [1:0]  src = 2'd0, mode = 2'd0;
    logic        fall = 1'b0;
    logic [15:0] pre = '0, post = 16'd1, dly = '0;
    logic [7:0]  rt = '0;
    logic        wr_en, pos_vld, busy, done, acc;
    logic [7:0]  waddr, pos;

    int errs = 0;
    int checks = 0;
    int cur = 0;

    acq_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .sample_vld_i(vld),
        .sw_trig_i(sw), .ext_trig_i(ext), .sync_trig_i(sy),
        .src_sel_i(src), .ext_fall_i(fall), .mode_i(mode),
        .pre_cnt_i(pre), .post_cnt_i(post), .delay_cnt_i(dly),
        .retrig_cnt_i(rt), .wr_en_o(wr_en), .wr_addr_o(waddr),
        .trig_pos_o(pos), .trig_pos_vld_o(pos_vld), .busy_o(busy),
        .done_o(done), .trig_acc_o(acc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic ck(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cur++;
    endtask

    task automatic go(input int n);
        while (cur < n) tick();
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] s, input logic f,
                         input int p, input int q, input int d, input int r);
        mode = m; src = s; fall = f;
        pre = 16'(p); post = 16'(q); dly = 16'(d); rt = 8'(r);
        arm = 1'b1;
        cur = 0;
        tick();
        arm = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 600 && busy; k++) tick();
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        ck("R1", "busy", busy, 0);
        ck("R1", "done", done, 0);
        ck("R1", "wr_en", wr_en, 0);
        ck("R1", "accept", acc, 0);
        ck("R1", "pos_vld", pos_vld, 0);
        ck("R1", "wr_addr", waddr, 0);
        rst_n = 1'b1;
        tick();

        // Table walk: one row per mode/retrigger combination
        for (int r = 0; r < 7; r++) begin
            vec_t v;
            int nwr, nacc, dcyc, w, g;
            v = TBL[r];
            nwr = 0; nacc = 0; dcyc = 0;
            w = int'(v.pre) + 3;
            g = int'(v.dly) + int'(v.post) + 3;
            start(v.mode, 2'd0, 1'b0, v.pre, v.post, v.dly, v.rt);
            for (int i = 1; i < 200 && dcyc == 0; i++) begin
                sw = 1'b0;
                for (int j = 0; j <= int'(v.rt); j++)
                    if (i == w + j * g) sw = 1'b1;
                #1;
                if (done) dcyc = i;
                else begin
                    nwr += int'(wr_en);
                    nacc += int'(acc);
                end
                tick();
            end
            sw = 1'b0;
            ck(mode_req(v.mode), "writes", nwr, v.ewr);
            ck((v.rt != 0) ? "R9" : mode_req(v.mode), "accepts", nacc, v.eacc);
            ck("R12", "done cycle", dcyc, v.edone);
            ck("R10", "trigger position", pos, v.epos);
        end

        // R7: triggers during pre fill are ignored, including the last fill cycle
        start(2'd2, 2'd0, 1'b0, 5, 1, 0, 0);
        go(3); sw = 1'b1; #1; ck("R7", "early trigger", acc, 0);
        go(5); #1; ck("R7", "last fill trigger", acc, 0);
        go(6); #1; ck("R7", "first allowed trigger", acc, 1);
        tick(); sw = 1'b0; #1;
        ck("R12", "done after pre", done, 1);
        ck("R12", "busy after pre", busy, 0);
        // R12: trigger while idle ignored
        sw = 1'b1; #1; ck("R12", "idle trigger", acc, 0);
        tick(); sw = 1'b0;
        ck("R12", "done held", done, 1);
        // R2: arm clears done and position-valid
        start(2'd0, 2'd0, 1'b0, 0, 4, 0, 1);
        ck("R2", "done cleared", done, 0);
        ck("R2", "pos_vld cleared", pos_vld, 0);
        ck("R2", "busy set", busy, 1);
        // R9: retrigger spacing in post mode (N=4)
        go(3); sw = 1'b1; #1; ck("R9", "first trigger", acc, 1);
        go(7); #1; ck("R9", "trigger inside segment", acc, 0);
        go(8); #1; ck("R9", "trigger at N+1", acc, 1);
        tick(); sw = 1'b0;
        wait_idle();

        // R4: external rising edge, two-flop latency; R3 unselected software
        start(2'd0, 2'd1, 1'b0, 0, 2, 0, 0);
        ext = 1'b1; #1; ck("R4", "rise latency 0", acc, 0);
        tick(); sw = 1'b1; #1;
        ck("R3", "software ignored on external source", acc, 0);
        sw = 1'b0;
        tick(); #1; ck("R4", "rise accepted", acc, 1);
        wait_idle();
        // R4: external falling edge
        start(2'd0, 2'd1, 1'b1, 0, 2, 0, 0);
        ext = 1'b0; tick(); #1; ck("R4", "fall latency 1", acc, 0);
        tick(); #1; ck("R4", "fall accepted", acc, 1);
        wait_idle();

        // R3: sync line, rising only; polarity setting does not apply
        start(2'd0, 2'd2, 1'b1, 0, 2, 0, 0);
        sy = 1'b1; tick();
        sw = 1'b1; ext = 1'b1; #1;
        ck("R3", "others ignored on sync source", acc, 0);
        sw = 1'b0;
        tick(); #1; ck("R3", "sync accepted", acc, 1);
        wait_idle();
        sy = 1'b0; ext = 1'b0; tick(); tick(); tick();

        // R2: arm during a capture is ignored
        start(2'd0, 2'd0, 1'b0, 0, 4, 0, 0);
        go(3); sw = 1'b1; tick(); sw = 1'b0;
        go(5); mode = 2'd2; arm = 1'b1; tick(); arm = 1'b0;
        go(8);
        ck("R2", "done despite re-arm", done, 1);
        ck("R2", "address kept", waddr, 4);

        // R13: gaps in sample-valid
        begin
            int nwr, dcyc;
            nwr = 0; dcyc = 0;
            start(2'd0, 2'd0, 1'b0, 0, 3, 0, 0);
            for (int i = 1; i < 40 && dcyc == 0; i++) begin
                vld = (i % 2) == 1;
                sw = (i == 3);
                #1;
                if (done) dcyc = i;
                else nwr += int'(wr_en);
                tick();
            end
            vld = 1'b1; sw = 1'b0;
            ck("R13", "writes with gaps", nwr, 3);
            ck("R13", "done with gaps", dcyc, 10);
        end

        // R11: address wrap in a long pre window
        start(2'd2, 2'd0, 1'b0, 250, 1, 0, 0);
        go(260); sw = 1'b1; #1; ck("R11", "accept after wrap", acc, 1);
        tick(); sw = 1'b0;
        ck("R11", "wrapped trigger position", pos, 3);
        ck("R10", "pos_vld", pos_vld, 1);
        ck("R11", "wrapped address", waddr, 4);

        // R3: source code 3 accepts nothing
        start(2'd0, 2'd3, 1'b0, 0, 2, 0, 0);
        sw = 1'b1; ext = 1'b1; sy = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 6; i++) begin
                #1; seen += int'(acc);
                tick();
                sw = 1'b0;
            end
            ck("R3", "no source accepts", seen, 0);
        end
        ck("R3", "still busy", busy, 1);
        rst_n = 1'b0; tick();
        ck("R1", "busy in reset", busy, 0);
        ck("R1", "wr_addr in reset", waddr, 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule